// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block derives an auxiliary clock from the system clock. A host write carries a requested division ratio. The block turns that ratio into a stored setting: a 3-bit divide code and a disable bit. Codes 0 to 6 divide by 2 × (code + 1), which gives even ratios from 2 to 14. Code 7 passes the input clock through undivided. A ratio that cannot be produced leaves the output off.

The stored setting is read back on two output ports, so software can see how its request was interpreted. The live divider does not take a new setting at once. It holds its current setting until the output's next falling edge, or takes the new one straight away if it is idle. Because of this, a ratio change never cuts a high phase short and never produces a runt pulse. Ratio 1 is produced by gating the input clock with an enable that is retimed on the falling input edge.

Top module: `clkout_div`

## Requirements
- R1: With an even ratio N from 2 to 14 active, the output is high for exactly N/2 input clocks and then low for exactly N/2 input clocks, repeating.
- R2: A write of ratio 1 stores code 7 with the disable bit clear. Once that setting is active, the output follows the input clock: high in every high half and low in every low half.
- R3: A write of ratio 0, of an odd ratio above 1, or of a ratio above 14 stores the disable bit set (1) and the code cleared to 0.
- R4: While the active setting is disabled, the output is held low. A disable that arrives during a high phase lets that high phase run its full length first.
- R5: A new setting written during a high phase takes effect only at the output's next falling edge. The current high phase keeps its old length, and the following phases use the new ratio.
- R6: Across every ratio change, entry into pass-through and exit from pass-through, no high pulse on the output is shorter than half an input clock period.
- R7: After synchronous reset the output is low, the stored code is 0 and the disable bit is set.
- R8: A write of an even ratio N from 2 to 14 stores code N/2 − 1 with the disable bit clear. The stored setting is visible on the readback ports in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the source clock to divide |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host write strobe for the ratio request |
| cfg_ratio | input | 4 | Requested division ratio, as an integer |
| clk_o | output | 1 | Divided, passed-through or held-low clock output |
| cfg_code_o | output | 3 | Stored divide code (7 means pass-through) |
| cfg_off_o | output | 1 | Stored disable bit (1 means output off) |

## Verification
The bench builds the block with its default 3-bit code and 4-bit ratio field. This makes every ratio request value from 0 to 15 reachable, so each legal ratio, each odd value, zero and the values above 14 can all be driven. The extreme divide ratios 2 and 14 and pass-through are measured by counting run lengths. Changes are issued right after a rising output edge, which is where an early switch would show up as a shortened high phase. A monitor records the width of every high pulse over the whole run.

// File: rtl/clkout_div_pkg.sv
package clkout_div_pkg;

    // Width of the stored divide code; the all-ones code selects pass-through.
    localparam int CLKDIV_CODE_W  = 3;
    // Width of the ratio request field; wide enough to hold the largest ratio.
    localparam int CLKDIV_RATIO_W = CLKDIV_CODE_W + 1;
    localparam logic [CLKDIV_CODE_W-1:0] CLKDIV_PASS_CODE = '1;
    // Largest even ratio reachable with the non-pass codes.
    localparam int CLKDIV_MAX_RATIO = 2 * ((1 << CLKDIV_CODE_W) - 1);

    typedef struct packed {
        logic                     off;
        logic [CLKDIV_CODE_W-1:0] code;
    } clkdiv_cfg_t;

    localparam clkdiv_cfg_t CLKDIV_CFG_RESET = '{off: 1'b1, code: '0};

    // Turn a requested integer ratio into the stored setting.
    function automatic clkdiv_cfg_t ratio_to_cfg(input logic [CLKDIV_RATIO_W-1:0] ratio);
        clkdiv_cfg_t                 c;
        logic [CLKDIV_RATIO_W-1:0]   half_m1;
        half_m1 = (ratio >> 1) - CLKDIV_RATIO_W'(1);
        if (ratio == CLKDIV_RATIO_W'(1)) begin
            c.off  = 1'b0;
            c.code = CLKDIV_PASS_CODE;
        end else if ((ratio != '0) && !ratio[0] &&
                     (int'(ratio) <= CLKDIV_MAX_RATIO)) begin
            c.off  = 1'b0;
            c.code = half_m1[CLKDIV_CODE_W-1:0];
        end else begin
            c = CLKDIV_CFG_RESET;
        end
        return c;
    endfunction

endpackage

// File: rtl/clkout_div_xlate.sv
module clkout_div_xlate
    import clkout_div_pkg::*;
#(
    parameter int RATIO_W = CLKDIV_RATIO_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [RATIO_W-1:0] wr_ratio,
    output clkdiv_cfg_t        cfg_q
);

    clkdiv_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d = ratio_to_cfg(CLKDIV_RATIO_W'(wr_ratio));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CLKDIV_CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/clkout_div_core.sv
module clkout_div_core
    import clkout_div_pkg::*;
#(
    parameter int CODE_W = CLKDIV_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  clkdiv_cfg_t       cfg,
    output logic              act_en,
    output logic [CODE_W-1:0] act_code,
    output logic              div_q,
    output logic              pass_q
);

    localparam logic [CODE_W-1:0] PASS = '1;

    logic [CODE_W-1:0] cnt;
    logic              act_pass;
    logic              half_done;
    logic              take_cfg;

    assign act_pass  = act_en && (act_code == PASS);
    assign half_done = (cnt == act_code);
    // A new setting is adopted only when the output is (or is about to go) low.
    assign take_cfg  = !act_en || act_pass || (div_q && half_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_en   <= 1'b0;
            act_code <= '0;
            cnt      <= '0;
            div_q    <= 1'b0;
            pass_q   <= 1'b0;
        end else if (take_cfg) begin
            act_en   <= !cfg.off;
            act_code <= cfg.code;
            cnt      <= '0;
            div_q    <= 1'b0;
            pass_q   <= !cfg.off && (cfg.code == PASS);
        end else if (half_done) begin
            cnt   <= '0;
            div_q <= !div_q;
        end else begin
            cnt <= cnt + CODE_W'(1);
        end
    end

endmodule

// File: rtl/clkout_div_drive.sv
module clkout_div_drive (
    input  logic clk,
    input  logic rst,
    input  logic div_q,
    input  logic pass_q,
    output logic clk_o
);

    // Pass-through enable retimed while the input clock is low, so the
    // gate below only opens or closes during a low input phase.
    logic pass_lo;

    always_ff @(negedge clk) begin
        if (rst) begin
            pass_lo <= 1'b0;
        end else begin
            pass_lo <= pass_q;
        end
    end

    assign clk_o = (clk & pass_lo) | div_q;

endmodule

// File: rtl/clkout_div.sv
module clkout_div
    import clkout_div_pkg::*;
#(
    parameter int CODE_W  = CLKDIV_CODE_W,
    parameter int RATIO_W = CODE_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [RATIO_W-1:0] cfg_ratio,
    output logic               clk_o,
    output logic [CODE_W-1:0]  cfg_code_o,
    output logic               cfg_off_o
);

    clkdiv_cfg_t       cfg_q;
    logic              act_en;
    logic [CODE_W-1:0] act_code;
    logic              div_q;
    logic              pass_q;

    clkout_div_xlate #(.RATIO_W(RATIO_W)) xlate_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_ratio (cfg_ratio),
        .cfg_q    (cfg_q)
    );

    clkout_div_core #(.CODE_W(CODE_W)) core_i (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg_q),
        .act_en   (act_en),
        .act_code (act_code),
        .div_q    (div_q),
        .pass_q   (pass_q)
    );

    clkout_div_drive drive_i (
        .clk    (clk),
        .rst    (rst),
        .div_q  (div_q),
        .pass_q (pass_q),
        .clk_o  (clk_o)
    );

    assign cfg_code_o = cfg_q.code;
    assign cfg_off_o  = cfg_q.off;

endmodule

// File: rtl/clkout_div_chk.sv
module clkout_div_chk #(
    parameter int CODE_W  = 3,
    parameter int RATIO_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_we,
    input logic [RATIO_W-1:0] cfg_ratio,
    input logic [CODE_W-1:0]  cfg_code_o,
    input logic               cfg_off_o,
    input logic               act_en,
    input logic [CODE_W-1:0]  act_code,
    input logic               div_q
);

    localparam logic [CODE_W-1:0] PASS = '1;
    localparam int MAXR = 2 * ((1 << CODE_W) - 1);

    // R7
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cfg_off_o && cfg_code_o == '0 && !div_q));

    // R3
    bad_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_ratio == '0 || int'(cfg_ratio) > MAXR ||
                    (cfg_ratio[0] && cfg_ratio != RATIO_W'(1))))
        |=> (cfg_off_o && cfg_code_o == '0));

    // R2
    pass_store_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_ratio == RATIO_W'(1)) |=> (!cfg_off_o && cfg_code_o == PASS));

    // R4
    off_low_chk: assert property (@(posedge clk) disable iff (rst)
        !act_en |-> !div_q);

    // R1
    rise_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(div_q) |-> (act_en && act_code != PASS));

    // R5
    high_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(div_q) && act_code != '0) |=> (div_q && $stable(act_code)));

endmodule

bind clkout_div clkout_div_chk #(.CODE_W(CODE_W), .RATIO_W(RATIO_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_ratio  (cfg_ratio),
    .cfg_code_o (cfg_code_o),
    .cfg_off_o  (cfg_off_o),
    .act_en     (act_en),
    .act_code   (act_code),
    .div_q      (div_q)
);

// File: tb/clkout_div_tb_top.sv
`timescale 1ns/1ps
module clkout_div_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_ratio = '0;
    logic       clk_o;
    logic [2:0] cfg_code_o;
    logic       cfg_off_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    real t_rise  = 0.0;
    real min_hi  = 1.0e9;

    always #2.5 clk = ~clk;

    clkout_div dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_ratio  (cfg_ratio),
        .clk_o      (clk_o),
        .cfg_code_o (cfg_code_o),
        .cfg_off_o  (cfg_off_o)
    );

    // High-pulse width monitor (R6)
    always @(posedge clk_o) t_rise = $realtime;
    always @(negedge clk_o) begin
        if (!rst && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int r);
        cfg_ratio = 4'(r);
        cfg_we    = 1'b1;
        step();
        cfg_we    = 1'b0;
    endtask

    // Count consecutive post-edge samples equal to the current level.
    task automatic run_len(output int n);
        logic lvl;
        lvl = clk_o;
        n = 0;
        while (clk_o == lvl && n < 100) begin
            n++;
            step();
        end
    endtask

    task automatic sync_rise();
        for (int i = 0; i < 64 && clk_o; i++) step();
        for (int i = 0; i < 64 && !clk_o; i++) step();
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk("R7 clk_o after reset", int'(clk_o), 0);
        chk("R7 code after reset", int'(cfg_code_o), 0);
        chk("R7 off after reset", int'(cfg_off_o), 1);
    endtask

    task automatic t_even(input int r);
        int h1, l1, h2, l2;
        wr(r);
        chk($sformatf("R8 code for ratio %0d", r), int'(cfg_code_o), r / 2 - 1);
        chk($sformatf("R8 off for ratio %0d", r), int'(cfg_off_o), 0);
        repeat (30) step();
        sync_rise();
        run_len(h1); run_len(l1); run_len(h2); run_len(l2);
        chk($sformatf("R1 high run ratio %0d", r), h1, r / 2);
        chk($sformatf("R1 low run ratio %0d", r), l1, r / 2);
        chk($sformatf("R1 second period ratio %0d", r), h2 + l2, r);
    endtask

    task automatic t_pass();
        int bad;
        wr(1);
        chk("R2 pass code", int'(cfg_code_o), 7);
        chk("R2 pass off", int'(cfg_off_o), 0);
        repeat (20) step();
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            if (clk_o !== 1'b1) bad++;
            @(negedge clk); #1;
            if (clk_o !== 1'b0) bad++;
        end
        chk("R2 output follows clock", bad, 0);
    endtask

    task automatic t_bad(input int r);
        int hi;
        wr(r);
        chk($sformatf("R3 off for ratio %0d", r), int'(cfg_off_o), 1);
        chk($sformatf("R3 code for ratio %0d", r), int'(cfg_code_o), 0);
        repeat (20) step();
        hi = 0;
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1;
            if (clk_o !== 1'b0) hi++;
            @(negedge clk); #1;
            if (clk_o !== 1'b0) hi++;
        end
        chk($sformatf("R4 held low after ratio %0d", r), hi, 0);
    endtask

    task automatic t_change();
        int h, l, h2;
        wr(14);
        repeat (40) step();
        sync_rise();
        wr(2);
        run_len(h);
        chk("R5 old high phase kept", h + 1, 7);
        run_len(l);
        run_len(h2);
        chk("R5 new low run", l, 1);
        chk("R5 new high run", h2, 1);
    endtask

    task automatic t_disable_mid();
        int h, hi;
        wr(14);
        repeat (40) step();
        sync_rise();
        wr(0);
        run_len(h);
        chk("R4 high phase completes before off", h + 1, 7);
        hi = 0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (clk_o) hi++;
        end
        chk("R4 low after disable", hi, 0);
    endtask

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_even(2);
        t_even(4);
        t_even(14);
        t_pass();
        t_even(6);
        t_pass();
        t_bad(0);
        t_pass();
        t_bad(3);
        t_even(8);
        t_bad(15);
        t_change();
        t_disable_mid();
        chk("R6 shortest high pulse in ps", int'(min_hi * 1000.0) >= 2400 ? 1 : 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule